// File: doc/BRIEF.md
# Parallel SAD Block Matcher

This block scores one 4x4 block of 8-bit pixels from the frame being coded against 18 candidate 4x4 blocks taken from a search window. Each candidate has its own processing element. In every accepted cycle the block receives one pixel of the coded block and, beside it, the pixel at the same position in each of the 18 candidates. The coded-block pixel goes to all elements at once. Each element adds the absolute difference between its candidate pixel and that shared pixel to a running sum of absolute differences (SAD).

Pixels arrive in row-major order, one matrix position per accepted cycle. A start pulse opens a new block. A valid strobe marks each pixel cycle, and gap cycles may fall anywhere. Once the sixteenth pixel has been taken, the block raises a one-cycle completion pulse. At that point all 18 sums are final, together with the position of the smallest sum and that sum's value. The results hold until the next start. That start may come in the very cycle the completion pulse is high. The caller is expected to release reset in step with the clock.

Top module: `sad_array`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0, every sum on `sad_o` is 0, and `best_idx_o` and `best_sad_o` are 0.
- R2: A start cycle with `valid_i` low sets all 18 sums to 0 in the next cycle, even in the middle of a block.
- R3: Each accepted pixel adds |candidate − current| (both unsigned 8-bit) to that candidate's sum. Candidate i is `cand_pix_i[8*i+7:8*i]`, and its sum is `sad_o[12*i+11:12*i]`.
- R4: `done_o` is high for exactly one cycle: the cycle right after the edge that takes the 16th pixel of a block. It is low at every other time.
- R5: After completion, the sums, `best_idx_o` and `best_sad_o` hold their values. `valid_i` cycles that come without a new start do not change them.
- R6: Cycles with `valid_i` low inside a block add nothing and do not count as pixels.
- R7: When `done_o` is high, `best_idx_o` is the lowest candidate index whose sum is the minimum, and `best_sad_o` equals that minimum.
- R8: When `start_i` and `valid_i` are high in the same cycle, the pixel on the inputs is taken as the block's first pixel.
- R9: A new block may start in the cycle where `done_o` is high, with no idle cycle in between.
- R10: The 12-bit sums reach 4080 (16 × 255) without wrapping, whichever of the two pixels is larger.
- R11: `valid_i` cycles after reset and before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new block and clears the sums |
| valid_i | input | 1 | Marks a pixel cycle |
| cur_pix_i | input | 8 | Pixel of the coded block, shared by all elements |
| cand_pix_i | input | 144 | 18 candidate pixels, candidate i at bits 8*i+7:8*i |
| done_o | output | 1 | One-cycle completion pulse |
| sad_o | output | 216 | 18 sums, candidate i at bits 12*i+11:12*i |
| best_idx_o | output | 5 | Index of the best candidate |
| best_sad_o | output | 12 | Smallest of the 18 sums |

## Verification
The assertions assume that `start_i` and `valid_i` change only away from the rising edge. They also assume that a block never holds more than 16 accepted pixels, which holds because the controller stops taking pixels after the sixteenth. The pixel buses are expected to carry meaningful data only when `valid_i` is high. The stimulus respects this: all inputs change on the falling edge, and junk appears on the pixel buses only in gap cycles or in cycles that the requirements say are ignored. The data sweeps cover differences in both directions, the saturating extremes 0 and 255, tied minima, gap patterns, and back-to-back blocks.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned PIX_W_DEF   = 8;
  localparam int unsigned N_CAND_DEF  = 18;
  localparam int unsigned BLK_PIX_DEF = 16;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } blk_state_e;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int unsigned BLK_PIX = BLK_PIX_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic clear_o,
  output logic take_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_PIX - 1);

  blk_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_base;
  logic             done_q, done_n;
  logic             take, last;

  always_comb begin
    take     = valid_i && (start_i || (state_q == ST_RUN));
    cnt_base = start_i ? '0 : cnt_q;
    last     = take && (cnt_base == LAST);
    state_n  = state_q;
    cnt_n    = cnt_q;
    if (start_i) begin
      state_n = ST_RUN;
    end
    if (take) begin
      cnt_n = cnt_base + 1'b1;
    end else if (start_i) begin
      cnt_n = '0;
    end
    if (last) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
    end
    done_n = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      done_q  <= done_n;
    end
  end

  assign clear_o = start_i;
  assign take_o  = take;
  assign done_o  = done_q;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done held longer than one cycle");

  assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE) && (cnt_q == '0))
    else $error("controller still running after completion");

  assert_no_take_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && state_q == ST_IDLE) |=> $stable(cnt_q))
    else $error("pixel counted outside a block");
endmodule

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] cand_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [PIX_W-1:0] absdiff;
  logic [ACC_W-1:0] acc_q, acc_n;

  always_comb begin
    absdiff = (cur_i >= cand_i) ? (cur_i - cand_i) : (cand_i - cur_i);
    acc_n   = acc_q;
    if (clear_i) begin
      acc_n = take_i ? ACC_W'(absdiff) : '0;
    end else if (take_i) begin
      acc_n = acc_q + ACC_W'(absdiff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_n;
    end
  end

  assign acc_o = acc_q;

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !take_i) |=> (acc_q == '0))
    else $error("sum not cleared by start");

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !take_i) |=> $stable(acc_q))
    else $error("sum moved without an accepted pixel");

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && take_i) |=> (acc_q >= $past(acc_q)))
    else $error("sum wrapped");
endmodule

// File: rtl/sad_min.sv
module sad_min #(
  parameter int unsigned N_CAND = 18,
  parameter int unsigned ACC_W  = 12,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [N_CAND-1:0][ACC_W-1:0] sad_i,
  output logic [IDX_W-1:0]             idx_o,
  output logic [ACC_W-1:0]             min_o
);
  always_comb begin
    idx_o = '0;
    min_o = sad_i[0];
    for (int i = 1; i < int'(N_CAND); i++) begin
      if (sad_i[i] < min_o) begin
        min_o = sad_i[i];
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sad_array.sv
module sad_array
  import sad_pkg::*;
#(
  parameter int unsigned PIX_W   = PIX_W_DEF,
  parameter int unsigned N_CAND  = N_CAND_DEF,
  parameter int unsigned BLK_PIX = BLK_PIX_DEF,
  localparam int unsigned ACC_W  = PIX_W + $clog2(BLK_PIX),
  localparam int unsigned IDX_W  = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic [PIX_W-1:0]        cur_pix_i,
  input  logic [N_CAND*PIX_W-1:0] cand_pix_i,
  output logic                    done_o,
  output logic [N_CAND*ACC_W-1:0] sad_o,
  output logic [IDX_W-1:0]        best_idx_o,
  output logic [ACC_W-1:0]        best_sad_o
);
  logic                         clear, take;
  logic [N_CAND-1:0][ACC_W-1:0] sad_arr;

  sad_ctrl #(.BLK_PIX(BLK_PIX)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .clear_o (clear),
    .take_o  (take),
    .done_o  (done_o)
  );

  for (genvar gi = 0; gi < int'(N_CAND); gi++) begin : g_pe
    sad_pe #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .take_i  (take),
      .cur_i   (cur_pix_i),
      .cand_i  (cand_pix_i[gi*PIX_W +: PIX_W]),
      .acc_o   (sad_arr[gi])
    );

    assert_min_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (best_sad_o <= sad_arr[gi]))
      else $error("reported minimum exceeds a candidate sum");

    assert_tie_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (gi < int'(best_idx_o))) |-> (sad_arr[gi] > best_sad_o))
      else $error("lower index ties the minimum");
  end

  sad_min #(.N_CAND(N_CAND), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_min (
    .sad_i (sad_arr),
    .idx_o (best_idx_o),
    .min_o (best_sad_o)
  );

  assign sad_o = sad_arr;

  assert_hold_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(sad_o))
    else $error("sums changed after completion");
endmodule

// File: tb/sad_array_bench.sv
module sad_array_bench;
  localparam int N = 18, P = 16, W = 8, AW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, start_i, valid_i;
  logic [W-1:0]   cur_pix_i;
  logic [N*W-1:0] cand_pix_i;
  logic           done_o;
  logic [N*AW-1:0] sad_o;
  logic [4:0]     best_idx_o;
  logic [AW-1:0]  best_sad_o;

  sad_array u_sad_array (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .cur_pix_i(cur_pix_i), .cand_pix_i(cand_pix_i), .done_o(done_o),
    .sad_o(sad_o), .best_idx_o(best_idx_o), .best_sad_o(best_sad_o)
  );

  int checks = 0, fails = 0;
  int bcur[P];
  int bcand[P][N];
  int exp_sad[N];
  int exp_idx, exp_min;
  logic [31:0] seed = 32'd2463;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_pix(int p);
    cur_pix_i = 8'(bcur[p]);
    for (int i = 0; i < N; i++) cand_pix_i[i*W +: W] = 8'(bcand[p][i]);
  endtask

  task automatic drive_junk();
    cur_pix_i = 8'(rnd());
    for (int i = 0; i < N; i++) cand_pix_i[i*W +: W] = 8'(rnd());
  endtask

  task automatic compute_exp();
    for (int i = 0; i < N; i++) begin
      exp_sad[i] = 0;
      for (int p = 0; p < P; p++)
        exp_sad[i] += (bcur[p] >= bcand[p][i]) ? bcur[p] - bcand[p][i] : bcand[p][i] - bcur[p];
    end
    exp_idx = 0;
    exp_min = exp_sad[0];
    for (int i = 1; i < N; i++)
      if (exp_sad[i] < exp_min) begin exp_min = exp_sad[i]; exp_idx = i; end
  endtask

  task automatic check_sums(string req);
    for (int i = 0; i < N; i++) chk(req, int'(sad_o[i*AW +: AW]), exp_sad[i]);
    chk({req, " R7 idx"}, int'(best_idx_o), exp_idx);
    chk({req, " R7 min"}, int'(best_sad_o), exp_min);
  endtask

  task automatic fill_random();
    for (int p = 0; p < P; p++) begin
      bcur[p] = rnd();
      for (int i = 0; i < N; i++) bcand[p][i] = rnd();
    end
  endtask

  // swf: first pixel rides on the start cycle; chain_in: caller is already at
  // the negedge where start must be driven; chain_out: leave at the done cycle
  task automatic send_block(bit swf, bit gaps, bit chain_in, bit chain_out, string req);
    compute_exp();
    if (!chain_in) @(negedge clk);
    start_i = 1'b1;
    valid_i = swf;
    if (swf) drive_pix(0); else drive_junk();
    for (int p = swf ? 1 : 0; p < P; p++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (p == 8) chk("R4 done low mid-block", int'(done_o), 0);
      if (gaps && (p % 3 == 1)) begin
        valid_i = 1'b0;
        drive_junk();
        @(negedge clk);
      end
      valid_i = 1'b1;
      drive_pix(p);
    end
    @(negedge clk);
    start_i = 1'b0;
    valid_i = 1'b0;
    drive_junk();
    chk("R4 done after 16th pixel", int'(done_o), 1);
    check_sums(req);
    if (!chain_out) begin
      @(negedge clk);
      chk("R4 done single cycle", int'(done_o), 0);
      valid_i = 1'b1;
      drive_junk();
      @(negedge clk);
      valid_i = 1'b0;
      @(negedge clk);
      chk("R5 done stays low", int'(done_o), 0);
      check_sums("R5 hold after extra valid");
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0;
    cur_pix_i = '0; cand_pix_i = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) exp_sad[i] = 0;
    exp_idx = 0; exp_min = 0;
    chk("R1 done in reset", int'(done_o), 0);
    check_sums("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_sums("R1 after release");

    // R11: valid before any start
    valid_i = 1'b1;
    repeat (3) begin drive_junk(); @(negedge clk); end
    valid_i = 1'b0;
    @(negedge clk);
    chk("R11 done", int'(done_o), 0);
    check_sums("R11 ignored");

    fill_random(); send_block(0, 0, 0, 0, "R3 random");
    fill_random(); send_block(0, 1, 0, 0, "R6 gaps");

    for (int p = 0; p < P; p++) begin
      bcur[p] = 0;
      for (int i = 0; i < N; i++) bcand[p][i] = 255;
    end
    send_block(0, 0, 0, 0, "R10 cand max");
    for (int p = 0; p < P; p++) begin
      bcur[p] = 255;
      for (int i = 0; i < N; i++) bcand[p][i] = 0;
    end
    send_block(0, 1, 0, 0, "R10 cur max");

    // R7: exact matches at 5 and 12, lowest wins
    fill_random();
    for (int p = 0; p < P; p++)
      for (int i = 0; i < N; i++)
        bcand[p][i] = (i == 5 || i == 12) ? bcur[p] : (bcur[p] ^ (1 + i));
    send_block(0, 0, 0, 0, "R7 tie 5/12");
    // R7: only the last candidate matches
    for (int p = 0; p < P; p++)
      for (int i = 0; i < N; i++)
        bcand[p][i] = (i == 17) ? bcur[p] : (bcur[p] ^ 8'h40);
    send_block(0, 0, 0, 0, "R7 last best");
    // R7: all equal, index 0
    for (int p = 0; p < P; p++)
      for (int i = 0; i < N; i++) bcand[p][i] = bcur[p] ^ 3;
    send_block(0, 1, 0, 0, "R7 all equal");

    fill_random(); send_block(1, 0, 0, 0, "R8 start with pixel");

    // R2: restart in mid-block clears the sums
    fill_random();
    @(negedge clk);
    start_i = 1'b1; valid_i = 1'b1; drive_pix(0);
    for (int p = 1; p < 5; p++) begin
      @(negedge clk); start_i = 1'b0; drive_pix(p);
    end
    @(negedge clk);
    start_i = 1'b1; valid_i = 1'b0; drive_junk();
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < N; i++) exp_sad[i] = 0;
    exp_idx = 0; exp_min = 0;
    chk("R2 done", int'(done_o), 0);
    check_sums("R2 mid-block clear");
    send_block(0, 0, 0, 0, "R2 block after restart");

    // R9: back-to-back blocks
    fill_random(); send_block(0, 0, 0, 1, "R9 first");
    fill_random(); send_block(1, 0, 1, 1, "R9 chained with pixel");
    fill_random(); send_block(0, 1, 1, 0, "R9 chained start only");

    // sweep of difference magnitudes and directions
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < P; p++) begin
        bcur[p] = (k * 17 + p * 5) & 255;
        for (int i = 0; i < N; i++) bcand[p][i] = (k * 37 + p * 11 + i * 29) & 255;
      end
      send_block(k[1], k[0], 0, 0, "R3 sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule